// File: doc/BRIEF.md
# SPI Serial Memory Read Slave

This block is the slave end of a four-wire SPI link that sits in front of a 2K x 8 byte memory. A fast system clock oversamples the serial clock, chip select, serial input and hold lines through two-flop synchronizers. The system clock must run at least eight times the serial clock rate. The block collects an 8-bit command. For a memory read it then takes a 16-bit address and streams bytes out MSB first. It advances through the array by itself and wraps from the top location to location zero.

A second command returns a status byte built from four live status inputs. That byte repeats for as long as the master keeps clocking. Any other command leaves the output undriven until chip select is released. The memory sits outside the block, behind a synchronous read port: the data appears one system clock after the request. The serial output comes with a separate enable, which the pad ring uses as the tri-state control.

Top module: `spi_rd_slave`

## Requirements
- R1: Out of reset, `so_oe` and `mem_rd_en` are both 0.
- R2: The command is the 8 bits sampled on the first eight SCK rising edges after CS_n falls, MSB first. Command 0x03 is a memory read. The next 16 rising edges give the address, MSB first. The byte at that address then leaves on `so` MSB first, and each bit changes after an SCK falling edge. The first bit follows the first falling edge after the last address bit.
- R3: `so_oe` is 0 while command and address bits are shifted in. It is 1 from that first output falling edge onward, while CS_n stays low and HOLD_n stays high. SI has no effect on the output data once output has begun.
- R4: Only the low 11 address bits select a location. Address bits 15 to 11 have no effect on the data returned.
- R5: After each byte of a memory read the location advances by one, and location 2047 is followed by location 0.
- R6: Command 0x05 returns the status byte {4'b0000, prot[1], prot[0], wen, busy}, bit 7 first. The byte is repeated for every further group of 8 clocks.
- R7: Any command other than 0x03 or 0x05 keeps `so_oe` at 0 until CS_n rises.
- R8: Mode 0 (SCK low at CS_n edges) and mode 3 (SCK high at CS_n edges) both work and return identical data.
- R9: While HOLD_n is low, `so_oe` is 0 and SCK and SI transitions are ignored. Releasing HOLD_n with SCK low resumes the transfer at the bit where it stopped.
- R10: Raising CS_n at any point, even mid-byte, drops `so_oe` and ends the sequence. The next CS_n fall starts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from the master |
| hold_n | input | 1 | Active-low transfer suspend |
| stat_prot | input | 2 | Block-protect status bits, placed at status bits 3:2 |
| stat_wen | input | 1 | Write-enable status bit, placed at status bit 1 |
| stat_busy | input | 1 | Busy/ready status bit, placed at status bit 0 |
| mem_rdata | input | 8 | Read data from memory, valid one clock after a request |
| so | output | 1 | Serial data to the master |
| so_oe | output | 1 | Drive enable for `so` (0 = high impedance) |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_addr | output | 11 | Memory read address |

## Verification
The bench reads across the top of the array. A design that failed to wrap would return data from a location that does not exist, or would stall the address counter. It sends addresses with the upper five bits set, which a design that decodes those bits would answer with the wrong byte. Each case is run in both SPI modes, because a design that treats the leading falling edge of mode 3 as data shifts every bit by one. It also suspends a transfer mid-byte with SCK and SI toggling and then aborts a read mid-byte. A design that honours edges while held, or keeps its state across chip select, returns a corrupted stream or enables the output too early.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_STAT,
    ST_DEAD
  } rd_state_t;

  localparam logic [7:0] OP_MEM_READ  = 8'h03;
  localparam logic [7:0] OP_STAT_READ = 8'h05;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int              W       = 4,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
      end
    end
    assign dout[i] = sync_q;
  end
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cs_s,
  input  logic hold_s,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_d_q;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d_q <= 1'b0;
    else        sck_d_q <= sck_s;
  end

  assign live     = ~cs_s & hold_s;
  assign sck_rise = live & sck_s & ~sck_d_q;
  assign sck_fall = live & ~sck_s & sck_d_q;
endmodule

// File: rtl/spi_rd_fsm.sv
module spi_rd_fsm
  import spi_rd_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int CMD_BITS  = 8,
  parameter int ADDR_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          si_s,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic [DW-1:0] stat_byte,
  input  logic [DW-1:0] mem_rdata,
  output logic          so,
  output logic          out_on,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr
);
  localparam int SW = ((AW > CMD_BITS) ? AW : CMD_BITS) - 1;
  localparam int CW = $clog2(ADDR_BITS);
  localparam int OW = $clog2(DW);
  localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_BITS - 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_BITS - 1);
  localparam logic [OW-1:0] OUT_LAST  = OW'(DW - 1);
  localparam logic [AW-1:0] ADDR_ONE  = AW'(1);

  rd_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] shin_q, shin_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          rden_q, rden_d;
  logic          rdv_q;
  logic [DW-1:0] nb_q;
  logic [DW-1:0] osh_q, osh_d;
  logic [OW-1:0] ocnt_q, ocnt_d;
  logic          so_q, so_d;
  logic          on_q, on_d;
  logic [DW-1:0] src_byte;
  logic [CMD_BITS-1:0] opcode;

  assign src_byte = (state_q == ST_STAT) ? stat_byte : nb_q;
  assign opcode   = {shin_q[CMD_BITS-2:0], si_s};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shin_d  = shin_q;
    addr_d  = addr_q;
    rden_d  = 1'b0;
    osh_d   = osh_q;
    ocnt_d  = ocnt_q;
    so_d    = so_q;
    on_d    = on_q;
    if (cs_s) begin
      state_d = ST_IDLE;
      on_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_CMD;
          cnt_d   = '0;
        end
        ST_CMD: if (sck_rise) begin
          shin_d = {shin_q[SW-2:0], si_s};
          cnt_d  = cnt_q + CW'(1);
          if (cnt_q == CMD_LAST) begin
            cnt_d  = '0;
            ocnt_d = '0;
            if (opcode == OP_MEM_READ)       state_d = ST_ADDR;
            else if (opcode == OP_STAT_READ) state_d = ST_STAT;
            else                             state_d = ST_DEAD;
          end
        end
        ST_ADDR: if (sck_rise) begin
          shin_d = {shin_q[SW-2:0], si_s};
          cnt_d  = cnt_q + CW'(1);
          if (cnt_q == ADDR_LAST) begin
            addr_d  = {shin_q[AW-2:0], si_s};
            rden_d  = 1'b1;
            ocnt_d  = '0;
            state_d = ST_DATA;
          end
        end
        ST_DATA, ST_STAT: if (sck_fall) begin
          on_d = 1'b1;
          if (ocnt_q == '0) begin
            so_d  = src_byte[DW-1];
            osh_d = {src_byte[DW-2:0], 1'b0};
            if (state_q == ST_DATA) begin
              addr_d = addr_q + ADDR_ONE;
              rden_d = 1'b1;
            end
          end else begin
            so_d  = osh_q[DW-1];
            osh_d = {osh_q[DW-2:0], 1'b0};
          end
          ocnt_d = (ocnt_q == OUT_LAST) ? '0 : ocnt_q + OW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shin_q  <= '0;
      addr_q  <= '0;
      rden_q  <= 1'b0;
      rdv_q   <= 1'b0;
      osh_q   <= '0;
      ocnt_q  <= '0;
      so_q    <= 1'b0;
      on_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shin_q  <= shin_d;
      addr_q  <= addr_d;
      rden_q  <= rden_d;
      rdv_q   <= rden_q;
      osh_q   <= osh_d;
      ocnt_q  <= ocnt_d;
      so_q    <= so_d;
      on_q    <= on_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     nb_q <= '0;
    else if (rdv_q) nb_q <= mem_rdata;
  end

  assign so        = so_q;
  assign out_on    = on_q;
  assign mem_rd_en = rden_q;
  assign mem_addr  = addr_q;
endmodule

// File: rtl/spi_rd_slave.sv
module spi_rd_slave #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int CMD_BITS  = 8,
  parameter int ADDR_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          hold_n,
  input  logic [1:0]    stat_prot,
  input  logic          stat_wen,
  input  logic          stat_busy,
  input  logic [DW-1:0] mem_rdata,
  output logic          so,
  output logic          so_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr
);
  logic          sck_s, cs_s, si_s, hold_s;
  logic          sck_rise, sck_fall;
  logic          out_on;
  logic [DW-1:0] stat_byte;

  spi_in_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({hold_n, si, cs_n, sck}),
    .dout ({hold_s, si_s, cs_s, sck_s})
  );

  spi_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_s),
    .cs_s    (cs_s),
    .hold_s  (hold_s),
    .sck_rise(sck_rise),
    .sck_fall(sck_fall)
  );

  assign stat_byte = {{(DW-4){1'b0}}, stat_prot, stat_wen, stat_busy};

  spi_rd_fsm #(.AW(AW), .DW(DW), .CMD_BITS(CMD_BITS), .ADDR_BITS(ADDR_BITS)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .si_s     (si_s),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .stat_byte(stat_byte),
    .mem_rdata(mem_rdata),
    .so       (so),
    .out_on   (out_on),
    .mem_rd_en(mem_rd_en),
    .mem_addr (mem_addr)
  );

  assign so_oe = out_on & ~cs_s & hold_s;
endmodule

// File: rtl/spi_rd_checker.sv
module spi_rd_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          hold_s,
  input logic          sck_fall,
  input logic          so,
  input logic          so_oe,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_addr
);
  logic          seen_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (cs_s) begin
      seen_q <= 1'b0;
    end else if (mem_rd_en) begin
      seen_q <= 1'b1;
      last_q <= mem_addr;
    end
  end

  assert_oe_off_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !so_oe);

  assert_oe_off_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |-> !so_oe);

  assert_rd_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_so_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && !$stable(so)) |-> $past(sck_fall));

  assert_addr_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && seen_q) |-> (mem_addr == AW'(last_q + AW'(1))));
endmodule

bind spi_rd_slave spi_rd_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_s     (cs_s),
  .hold_s   (hold_s),
  .sck_fall (sck_fall),
  .so       (so),
  .so_oe    (so_oe),
  .mem_rd_en(mem_rd_en),
  .mem_addr (mem_addr)
);

// File: tb/spi_rd_slave_tb.sv
module spi_rd_slave_tb_top;
  localparam int H = 6;
  localparam int NV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic [1:0] stat_prot = 2'b00;
  logic stat_wen = 1'b0, stat_busy = 1'b0;
  logic [7:0] mem_rdata;
  logic so, so_oe, mem_rd_en;
  logic [10:0] mem_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_rd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .stat_prot(stat_prot), .stat_wen(stat_wen), .stat_busy(stat_busy),
    .mem_rdata(mem_rdata), .so(so), .so_oe(so_oe), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr)
  );

  function automatic logic [7:0] memv(input int a);
    return 8'((a * 37 + (a >> 7)) ^ 8'h5A);
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= memv(int'(mem_addr));

  // fields: op[37:30] addr[29:14] nbytes[13:6] mode3[5] hold[4] stat[3:0]
  localparam logic [37:0] VEC [NV] = '{
    {8'h03, 16'h0010, 8'd3, 1'b0, 1'b0, 4'h0},
    {8'h03, 16'hF805, 8'd2, 1'b1, 1'b0, 4'h0},
    {8'h03, 16'h07FE, 8'd4, 1'b0, 1'b0, 4'h0},
    {8'h05, 16'h0000, 8'd3, 1'b1, 1'b0, 4'hA},
    {8'h05, 16'h0000, 8'd2, 1'b0, 1'b0, 4'h5},
    {8'h06, 16'h0000, 8'd2, 1'b0, 1'b0, 4'h0},
    {8'h03, 16'h0123, 8'd2, 1'b1, 1'b1, 4'h0},
    {8'h03, 16'h07FF, 8'd2, 1'b1, 1'b0, 4'h0}
  };

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one SCK period: low phase (drive SI, sample SO/OE at its end), high phase
  task automatic bitcyc(input bit din, input bit do_hold, output bit dout, output bit oe);
    sck = 1'b0;
    si  = din;
    if (do_hold) begin
      wclk(2);
      hold_n = 1'b0;
      wclk(H);
      chk(so_oe == 1'b0, "R9 oe during hold", so_oe, 0);
      for (int k = 0; k < 2; k++) begin
        sck = 1'b1; si = ~si; wclk(H);
        sck = 1'b0; wclk(H);
      end
      hold_n = 1'b1;
    end
    wclk(H);
    dout = so;
    oe   = so_oe;
    sck  = 1'b1;
    wclk(H);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [15:0] addr, input int nb,
                      input bit mode3, input bit hold, input logic [3:0] st, input string tag);
    bit d, oe, bad_in, bad_out;
    int ninb;
    logic [7:0] got, exp;
    logic [23:0] word;
    stat_prot = st[3:2]; stat_wen = st[1]; stat_busy = st[0];
    word = {op, addr};
    ninb = (op == 8'h03) ? 24 : 8;
    bad_in = 0; bad_out = 0;
    sck = mode3;
    wclk(H);
    cs_n = 1'b0;
    wclk(H);
    for (int i = 0; i < ninb; i++) begin
      bitcyc(word[23 - i], 1'b0, d, oe);
      if (oe) bad_in = 1;
    end
    for (int b = 0; b < nb; b++) begin
      got = '0;
      for (int i = 0; i < 8; i++) begin
        bitcyc(i[0], hold && b == 0 && i == 3, d, oe);
        got = {got[6:0], d};
        if (op == 8'h03 || op == 8'h05) begin
          if (!oe) bad_out = 1;
        end else if (oe) bad_in = 1;
      end
      if (op == 8'h03) exp = memv((int'(addr[10:0]) + b) % 2048);
      else             exp = {4'b0000, st};
      if (op == 8'h03 || op == 8'h05)
        chk(got == exp, {tag, " data byte"}, got, exp);
    end
    if (!mode3) begin sck = 1'b0; wclk(H); end
    cs_n = 1'b1;
    wclk(H);
    chk(!bad_in, {tag, " R3/R7 oe low outside data"}, bad_in, 0);
    if (op == 8'h03 || op == 8'h05)
      chk(!bad_out, {tag, " R3 oe high in data"}, bad_out, 0);
    chk(so_oe == 1'b0, {tag, " R10 oe after cs rise"}, so_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit d, oe;
    wclk(3);
    chk(so_oe == 1'b0, "R1 reset so_oe", so_oe, 0);
    chk(mem_rd_en == 1'b0, "R1 reset mem_rd_en", mem_rd_en, 0);
    rst_n = 1'b1;
    wclk(4);
    chk(so_oe == 1'b0 && mem_rd_en == 1'b0, "R1 after release", so_oe, 0);

    // R2 R3 R4 R5 R6 R7 R8 R9 via the vector table
    for (int v = 0; v < NV; v++)
      xfer(VEC[v][37:30], VEC[v][29:14], int'(VEC[v][13:6]), VEC[v][5], VEC[v][4],
           VEC[v][3:0], $sformatf("vec%0d R2/R4/R5/R6/R8", v));

    // R10: abort a read after three data bits, then start fresh
    sck = 1'b0; wclk(H); cs_n = 1'b0; wclk(H);
    for (int i = 0; i < 24; i++) begin
      logic [23:0] w;
      w = {8'h03, 16'h0040};
      bitcyc(w[23 - i], 1'b0, d, oe);
    end
    for (int i = 0; i < 3; i++) bitcyc(1'b0, 1'b0, d, oe);
    chk(oe == 1'b1, "R10 oe mid byte before abort", oe, 1);
    sck = 1'b0; wclk(H);
    cs_n = 1'b1;
    wclk(H);
    chk(so_oe == 1'b0, "R10 oe after mid-byte abort", so_oe, 0);
    xfer(8'h03, 16'h0041, 1, 1'b0, 1'b0, 4'h0, "R10 fresh read");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule